// File: doc/BRIEF.md
# Hardware Trap Arbitration Controller

This block sits beside a CPU core and turns run-time exception events into one trap request at a time. Each event pulse sets its own sticky bit in a flag register. Five groups of sources take part in arbitration: a restart group, three single-cause urgent sources (non-maskable interrupt, stack overflow, stack underflow) and a group of five instruction or bus faults. The group of faults shares one entry point, so software reads the flag register to tell the causes apart. The controller picks the most urgent pending group and presents a registered vector address and trap number. The request stays on until the core acknowledges it.

The block tracks the service level of the trap now running. It takes a new hardware trap only when that trap ranks strictly above this level. When the core acknowledges a request, the old level goes onto a small stack, and a return strobe takes it back off. A software trap instruction supplies any 7-bit trap number. It is latched and served at the current level, after any hardware trap that is eligible at the same time. While the service level is above zero, an output tells the interrupt controller to hold off ordinary interrupts and event-controller transfers.

Top module: `trap_ctrl`

## Requirements
- R1: `flags_o` is sticky. Bit k is set in the cycle after `evt_i[k]` is high. It is cleared in the cycle after a write with `clr_we_i` high and `clr_mask_i[k]` high. When a clear and an event for the same bit come in one cycle, the bit stays set. Bit layout: [4:0] instruction/bus faults, [5] stack underflow, [6] stack overflow, [7] non-maskable interrupt, [8] restart.
- R2: After reset, `req_o`, `flags_o`, `svc_lvl_o` and `irq_block_o` are all zero.
- R3: Hardware requests carry these trap numbers, vectors and levels. Restart: 0x00, 0x000000, level 3. Non-maskable interrupt: 0x02, 0x000008, level 2. Stack overflow: 0x04, 0x000010, level 2. Stack underflow: 0x06, 0x000018, level 2. Any of flag bits [4:0]: 0x0A, 0x000028, level 1.
- R4: When several sources are pending, the order is restart, then non-maskable interrupt, then stack overflow, then stack underflow, then the fault group.
- R5: A pending hardware trap is requested only when its level is strictly above `svc_lvl_o`. Otherwise it stays pending until returns lower the level.
- R6: A request appears the cycle after its source becomes pending. `req_o`, `vec_o` and `num_o` then hold steady until `ack_i`.
- R7: `ack_i` while `req_o` is high does four things. It drops the request, pushes the current level, sets `svc_lvl_o` to the request's level and clears that source's pending state (all fault-group causes at once). `ack_i` without a request is ignored.
- R8: `ret_i` pops the saved level. On an empty stack it sets the level to 0. When `ack_i` and `ret_i` accept in the same cycle, the acknowledge is applied and the return is dropped.
- R9: `irq_block_o` is high exactly when `svc_lvl_o` is nonzero.
- R10: A software trap with number n is latched and requested with `num_o` = n and `vec_o` = 4*n, at the current level. An eligible hardware trap is requested first.
- R11: Hardware requests never carry trap numbers 0x0B to 0x0F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 9 | One-cycle event pulses, layout as in R1 |
| clr_we_i | input | 1 | Flag clear write strobe |
| clr_mask_i | input | 9 | Flags to clear, one bit per flag |
| swt_i | input | 1 | Software trap instruction strobe |
| swt_num_i | input | 7 | Software trap number |
| ack_i | input | 1 | Core acknowledges the request |
| ret_i | input | 1 | Return-from-trap strobe |
| req_o | output | 1 | Trap request to the core |
| vec_o | output | 24 | Vector address of the request |
| num_o | output | 7 | Trap number of the request |
| flags_o | output | 9 | Sticky trap flag register |
| svc_lvl_o | output | 2 | Level of the trap in service |
| irq_block_o | output | 1 | Hold off ordinary interrupts |

## Verification
The hardest case to reach is a trap that stays pending at equal or lower level and comes out only after one or more returns. A related case has three nested levels and then unwinds. The stimulus gets there with directed runs that raise a second event of equal or lower level during service, raise a restart inside a fault-group service, and issue acknowledge and return in the same cycle. A long seeded random phase then mixes sparse events, flag clears, software traps and returns. A bench model with its own level stack follows every step.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NUM_W = 7;
  localparam int VEC_W = 24;
  localparam int NSRC  = 5;
  localparam int NB    = 5;
  localparam int NFLAG = NB + NSRC - 1;
  localparam int LVL_W = 2;
  localparam int SRC_W = 3;

  // arbitration slots, a higher index wins
  localparam int S_B   = 0;
  localparam int S_SUF = 1;
  localparam int S_SOF = 2;
  localparam int S_NMI = 3;
  localparam int S_RST = 4;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [NUM_W-1:0] num_t;

  typedef struct packed {
    logic             hw;
    logic [SRC_W-1:0] src;
    lvl_t             lvl;
    num_t             num;
  } req_t;

  function automatic num_t src_num(input int s);
    case (s)
      S_RST:   return 7'h00;
      S_NMI:   return 7'h02;
      S_SOF:   return 7'h04;
      S_SUF:   return 7'h06;
      default: return 7'h0A;
    endcase
  endfunction

  function automatic lvl_t src_lvl(input int s);
    case (s)
      S_RST:   return 2'd3;
      S_B:     return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] num_vec(input num_t n);
    return VEC_W'(n) << 2;
  endfunction
endpackage

// File: rtl/trap_flags.sv
module trap_flags
  import trap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] clr_mask,
  input  logic             take,
  input  logic [SRC_W-1:0] take_src,
  output logic [NFLAG-1:0] flags,
  output logic [NSRC-1:0]  pend
);
  logic [NSRC-1:0] pend_set;
  logic [NSRC-1:0] pend_drop;

  assign pend_set[S_B] = |evt[NB-1:0];
  for (genvar i = 1; i < NSRC; i++) begin : g_map
    assign pend_set[i] = evt[NB+i-1];
  end

  assign pend_drop = take ? (NSRC'(1) << take_src) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      pend  <= '0;
    end else begin
      flags <= (flags & ~(clr_we ? clr_mask : '0)) | evt;
      pend  <= (pend & ~pend_drop) | pend_set;
    end
  end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic [NSRC-1:0]  pend,
  input  lvl_t             cur_lvl,
  output logic             win_valid,
  output logic [SRC_W-1:0] win_src
);
  logic found;

  always_comb begin
    found   = 1'b0;
    win_src = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (pend[s]) begin
        found   = 1'b1;
        win_src = SRC_W'(s);
      end
    end
    win_valid = found && (src_lvl(int'(win_src)) > cur_lvl);
  end
endmodule

// File: rtl/trap_prio_stack.sv
module trap_prio_stack
  import trap_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  lvl_t new_lvl,
  output lvl_t cur_lvl
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  lvl_t             stk [DEPTH];
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cur_lvl <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (push) begin
      if (int'(cnt) < DEPTH) begin
        stk[cnt] <= cur_lvl;
        cnt      <= cnt + 1'b1;
      end
      cur_lvl <= new_lvl;
    end else if (pop) begin
      if (cnt != '0) begin
        cur_lvl <= stk[cnt-1'b1];
        cnt     <= cnt - 1'b1;
      end else begin
        cur_lvl <= '0;
      end
    end
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int STACK_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt_i,
  input  logic             clr_we_i,
  input  logic [NFLAG-1:0] clr_mask_i,
  input  logic             swt_i,
  input  logic [NUM_W-1:0] swt_num_i,
  input  logic             ack_i,
  input  logic             ret_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [NUM_W-1:0] num_o,
  output logic [NFLAG-1:0] flags_o,
  output logic [LVL_W-1:0] svc_lvl_o,
  output logic             irq_block_o
);
  req_t             req_q;
  logic             req_v_q;
  logic             swp_q;
  num_t             swn_q;
  logic [NSRC-1:0]  pend;
  logic             win_valid;
  logic [SRC_W-1:0] win_src;
  lvl_t             cur_lvl;

  // named internal events, also seen by the checker
  logic accept, pop, load_hw, load_sw, req_hw;
  lvl_t req_lvl;

  assign accept  = ack_i & req_v_q;
  assign pop     = ret_i & ~accept;
  assign load_hw = ~req_v_q & win_valid;
  assign load_sw = ~req_v_q & ~win_valid & swp_q;
  assign req_hw  = req_q.hw;
  assign req_lvl = req_q.lvl;

  trap_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_i),
    .clr_we   (clr_we_i),
    .clr_mask (clr_mask_i),
    .take     (accept & req_q.hw),
    .take_src (req_q.src),
    .flags    (flags_o),
    .pend     (pend)
  );

  trap_arbiter u_arb (
    .pend      (pend),
    .cur_lvl   (cur_lvl),
    .win_valid (win_valid),
    .win_src   (win_src)
  );

  trap_prio_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (accept),
    .pop     (pop),
    .new_lvl (req_q.lvl),
    .cur_lvl (cur_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_v_q <= 1'b0;
      req_q   <= '0;
      swp_q   <= 1'b0;
      swn_q   <= '0;
    end else begin
      if (accept) begin
        req_v_q <= 1'b0;
      end else if (load_hw) begin
        req_v_q <= 1'b1;
        req_q   <= '{hw: 1'b1, src: win_src,
                     lvl: src_lvl(int'(win_src)), num: src_num(int'(win_src))};
      end else if (load_sw) begin
        req_v_q <= 1'b1;
        req_q   <= '{hw: 1'b0, src: '0, lvl: cur_lvl, num: swn_q};
      end
      if (swt_i) begin
        swp_q <= 1'b1;
        swn_q <= swt_num_i;
      end else if (load_sw) begin
        swp_q <= 1'b0;
      end
    end
  end

  assign req_o       = req_v_q;
  assign num_o       = req_q.num;
  assign vec_o       = num_vec(req_q.num);
  assign svc_lvl_o   = cur_lvl;
  assign irq_block_o = (cur_lvl != '0);
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk
  import trap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NFLAG-1:0] evt_i,
  input logic             clr_we_i,
  input logic [NFLAG-1:0] clr_mask_i,
  input logic             ack_i,
  input logic             req_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [NUM_W-1:0] num_o,
  input logic [NFLAG-1:0] flags_o,
  input logic [LVL_W-1:0] svc_lvl_o,
  input logic             irq_block_o,
  input logic             accept,
  input logic             load_hw,
  input logic             req_hw,
  input lvl_t             req_lvl
);
  logic [NFLAG-1:0] keep_mask;
  assign keep_mask = flags_o & ~(clr_we_i ? clr_mask_i : '0);

  assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

  assert_flag_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & $past(keep_mask)) == $past(keep_mask)));

  assert_vec_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (vec_o[1:0] == 2'b00 && vec_o[VEC_W-1:2] == (VEC_W-2)'(num_o)));

  assert_preempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_hw |=> (req_lvl > $past(svc_lvl_o)));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(vec_o) && $stable(num_o)));

  assert_take_lvl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (svc_lvl_o == $past(req_lvl)));

  assert_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_lvl != '0) |=> irq_block_o);

  assert_no_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && req_hw) |-> !(num_o inside {[7'h0B:7'h0F]}));
endmodule

bind trap_ctrl trap_ctrl_chk u_chk (.*);

// File: tb/trap_ctrl_tb.sv
`timescale 1ns/1ps
module trap_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  evt_i = '0;
  logic        clr_we_i = 1'b0;
  logic [8:0]  clr_mask_i = '0;
  logic        swt_i = 1'b0;
  logic [6:0]  swt_num_i = '0;
  logic        ack_i = 1'b0;
  logic        ret_i = 1'b0;
  logic        req_o;
  logic [23:0] vec_o;
  logic [6:0]  num_o;
  logic [8:0]  flags_o;
  logic [1:0]  svc_lvl_o;
  logic        irq_block_o;

  always #2 clk = ~clk;

  trap_ctrl u_dut (.*);

  int n_chk = 0;
  int n_err = 0;

  // bench model
  logic [8:0] m_flags;
  logic [4:0] m_pend;
  bit         m_swp;
  logic [6:0] m_swn;
  bit         m_req, m_hw;
  int         m_src, m_lvl, m_cur;
  logic [6:0] m_num;
  int         stk[$];

  function automatic int b_lvl(int s);
    if (s == 4) return 3;
    if (s == 0) return 1;
    return 2;
  endfunction

  function automatic logic [6:0] b_num(int s);
    logic [6:0] t[5] = '{7'd10, 7'd6, 7'd4, 7'd2, 7'd0};
    return t[s];
  endfunction

  function automatic logic [23:0] b_vec(logic [6:0] n);
    return 24'(n) * 24'd4;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(req_o == m_req, "R6 req", 32'(req_o), 32'(m_req));
    if (m_req && req_o) begin
      chk(num_o == m_num, m_hw ? "R3 num" : "R10 num", 32'(num_o), 32'(m_num));
      chk(vec_o == b_vec(m_num), m_hw ? "R3 vec" : "R10 vec", 32'(vec_o), 32'(b_vec(m_num)));
      if (m_hw) chk(!(num_o >= 7'h0B && num_o <= 7'h0F), "R11 reserved", 32'(num_o), 32'h0A);
    end
    chk(flags_o == m_flags, "R1 flags", 32'(flags_o), 32'(m_flags));
    chk(int'(svc_lvl_o) == m_cur, "R7/R8 level", 32'(svc_lvl_o), 32'(m_cur));
    chk(irq_block_o == (m_cur != 0), "R9 block", 32'(irq_block_o), 32'(m_cur != 0));
  endtask

  task automatic step(logic [8:0] ev, bit cw, logic [8:0] cm, bit sw,
                      logic [6:0] swn, bit ack, bit ret);
    bit acc, ld_hw, ld_sw;
    int top;
    evt_i = ev; clr_we_i = cw; clr_mask_i = cm; swt_i = sw; swt_num_i = swn;
    ack_i = ack; ret_i = ret;
    acc = ack && m_req;
    top = -1;
    for (int s = 4; s >= 0; s--) if (m_pend[s] && top < 0) top = s;
    ld_hw = !m_req && top >= 0 && b_lvl(top) > m_cur;
    ld_sw = !m_req && !ld_hw && m_swp;
    m_flags = (m_flags & ~(cw ? cm : 9'h0)) | ev;
    if (acc && m_hw) m_pend[m_src] = 1'b0;
    if (ev[4:0] != 0) m_pend[0] = 1'b1;
    for (int k = 1; k < 5; k++) if (ev[4+k]) m_pend[k] = 1'b1;
    if (acc) m_req = 0;
    else if (ld_hw) begin
      m_req = 1; m_hw = 1; m_src = top; m_lvl = b_lvl(top); m_num = b_num(top);
    end else if (ld_sw) begin
      m_req = 1; m_hw = 0; m_src = 0; m_lvl = m_cur; m_num = m_swn;
    end
    if (sw) begin m_swp = 1; m_swn = swn; end
    else if (ld_sw) m_swp = 0;
    if (acc) begin
      stk.push_back(m_cur);
      m_cur = (ld_hw || ld_sw) ? m_cur : m_lvl;
    end else if (ret) begin
      m_cur = (stk.size() > 0) ? stk.pop_back() : 0;
    end
    @(posedge clk);
    @(negedge clk);
    evt_i = '0; clr_we_i = 0; swt_i = 0; ack_i = 0; ret_i = 0;
    compare();
  endtask

  // m_lvl is still the acknowledged request's level when acc is set
  task automatic idle(); step('0, 0, '0, 0, '0, 0, 0); endtask
  task automatic ev(logic [8:0] e); step(e, 0, '0, 0, '0, 0, 0); endtask
  task automatic ack(); step('0, 0, '0, 0, '0, 1, 0); endtask
  task automatic ret(); step('0, 0, '0, 0, '0, 0, 1); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_71a7));
    m_flags = '0; m_pend = '0; m_swp = 0; m_swn = '0; m_req = 0; m_hw = 0;
    m_src = 0; m_lvl = 0; m_cur = 0; m_num = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    chk(req_o == 0 && flags_o == 0, "R2 req/flags", 32'({req_o, flags_o}), 32'h0);
    chk(svc_lvl_o == 0 && irq_block_o == 0, "R2 level", 32'({svc_lvl_o, irq_block_o}), 32'h0);

    // R3: non-maskable interrupt alone
    ev(9'h080); idle();
    chk(num_o == 7'h02 && vec_o == 24'h8, "R3 nmi", 32'(vec_o), 32'h8);
    ack();
    chk(svc_lvl_o == 2 && irq_block_o, "R9 block in service", 32'(svc_lvl_o), 32'h2);
    // R5: equal level held until return
    ev(9'h040); idle();
    chk(req_o == 0, "R5 equal level held", 32'(req_o), 32'h0);
    ret(); idle();
    chk(req_o && num_o == 7'h04, "R5 released", 32'(num_o), 32'h4);
    ack(); ret();

    // R4: three pending at once
    ev(9'h0A1); idle();
    chk(num_o == 7'h02, "R4 first", 32'(num_o), 32'h2);
    ack(); ret(); idle();
    chk(num_o == 7'h06, "R4 second", 32'(num_o), 32'h6);
    ack(); ret(); idle();
    chk(num_o == 7'h0A && vec_o == 24'h28, "R3 fault group", 32'(vec_o), 32'h28);
    ack(); ret();

    // R1: clear and event on the same cycle
    step(9'h002, 1, 9'h1FF, 0, '0, 0, 0);
    chk(flags_o == 9'h002, "R1 clear vs set", 32'(flags_o), 32'h2);
    idle(); ack();
    // restart preempts the fault group, nmi waits
    ev(9'h100); idle();
    chk(num_o == 7'h00 && vec_o == 24'h0, "R3 restart", 32'(vec_o), 32'h0);
    ack(); ev(9'h080); idle();
    chk(req_o == 0, "R5 lower level held", 32'(req_o), 32'h0);
    ret(); idle(); ack(); ret(); ret();
    ret();
    chk(svc_lvl_o == 0, "R8 empty pop", 32'(svc_lvl_o), 32'h0);
    // R8: ack and return together
    ev(9'h020); idle();
    step('0, 0, '0, 0, '0, 1, 1);
    chk(svc_lvl_o == 2, "R8 ack wins", 32'(svc_lvl_o), 32'h2);
    ret();

    // R10: software trap
    step('0, 0, '0, 1, 7'h7F, 0, 0); idle();
    chk(num_o == 7'h7F && vec_o == 24'h1FC, "R10 sw vector", 32'(vec_o), 32'h1FC);
    ack();
    chk(irq_block_o == 0, "R9 sw at level 0", 32'(irq_block_o), 32'h0);
    ret();
    step(9'h040, 0, '0, 1, 7'h20, 0, 0); idle();
    chk(num_o == 7'h04, "R10 hw first", 32'(num_o), 32'h4);
    ack(); idle();
    chk(num_o == 7'h20 && vec_o == 24'h80, "R10 sw after", 32'(vec_o), 32'h80);
    ack(); ret(); ret();
    ack();
    chk(svc_lvl_o == 0, "R7 ack ignored", 32'(svc_lvl_o), 32'h0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [8:0] e;
      bit cw, sw, a, r;
      e = '0;
      for (int b = 0; b < 9; b++) if ($urandom_range(0, 59) == 0) e[b] = 1'b1;
      cw = ($urandom_range(0, 9) == 0);
      sw = !m_swp && stk.size() < 4 && ($urandom_range(0, 24) == 0);
      a  = ($urandom_range(0, 2) != 0);
      r  = ($urandom_range(0, 5) == 0);
      step(e, cw, 9'($urandom), sw, 7'($urandom), a, r);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule